// File: doc/BRIEF.md
# Nibble Register File with Pair Access

This block holds the general-purpose scratch storage of a small 4-bit processor: sixteen 4-bit registers. Each register can be reached on its own through a 4-bit index, or two neighbouring registers can be reached together as one 8-bit pair through a 3-bit pair index. Both views map onto the same storage. Because of this, anything written through one view shows up at once through the other.

There is one write port and one read port for each view. Writes are committed on the rising clock edge. Reads are combinational from the stored contents. Two inputs zero every register. The active-low `rstN` does it at once. The `clr` input does it synchronously, at the next clock edge. A single write and a pair write may land on the same register in the same cycle. When they do, the pair write takes that register.

Top module: `nibble_regfile`

## Requirements
- R1: After `rstN` is asserted, every register reads 0. After a cycle with `clr` high, every register also reads 0.
- R2: A single write with `singleWe` high stores `singleWrData` into register `singleWrIdx` at the clock edge. From the next cycle, reading that index on the single read port returns the value.
- R3: A pair write with `pairWe` high stores bits 7:4 of `pairWrData` into register 2p, where p is `pairWrIdx`.
- R4: The same pair write stores bits 3:0 of `pairWrData` into register 2p+1.
- R5: The pair read port returns register 2p on bits 7:4 of `pairRdData` and register 2p+1 on bits 3:0, where p is `pairRdIdx`.
- R6: A single write to either register of a pair is visible through the pair read port in the next cycle.
- R7: A pair write is visible through the single read port for both registers in the next cycle.
- R8: A single write and a pair write may arrive in the same cycle. If they target the same register, the pair data is stored. If they target different registers, both writes are stored.
- R9: In a cycle with `singleWe`, `pairWe` and `clr` all low, no register changes, whatever values sit on the write index and data inputs.
- R10: When `clr` is high together with any write enable, the clear wins and every register becomes 0.
- R11: Both read ports follow their index inputs combinationally within the same cycle. No clock edge is needed between an index change and the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Writes and the clear act on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset. Zeroes all registers |
| clr | input | 1 | Synchronous clear of all registers. Overrides both writes |
| singleWe | input | 1 | Write enable for the single-register view |
| singleWrIdx | input | 4 | Register index for the single write |
| singleWrData | input | 4 | Nibble to be written by the single write |
| pairWe | input | 1 | Write enable for the pair view |
| pairWrIdx | input | 3 | Pair index p for the pair write (registers 2p, 2p+1) |
| pairWrData | input | 8 | Byte to be written. 7:4 goes to the even register, 3:0 to the odd one |
| singleRdIdx | input | 4 | Register index for the single read |
| singleRdData | output | 4 | Contents of register `singleRdIdx` |
| pairRdIdx | input | 3 | Pair index for the pair read |
| pairRdData | output | 8 | {register 2p, register 2p+1} |

## Verification
The bench builds the block with its default parameters: sixteen registers of four bits. These values give a 4-bit single index and a 3-bit pair index, so every register and every pair can be swept exhaustively in a few hundred cycles. With sixteen registers, both kinds of collision can be reached. These are a single write to the even half of the pair being written and a single write to the odd half. The bench also covers simultaneous writes to unrelated pairs and a clear that coincides with both writes. The same parameters exercise aliasing in both directions: single writes observed through the pair port, and pair writes observed through the single port.

// File: rtl/nrf_pkg.sv
`timescale 1ns/1ps
package nrf_pkg;

  // Strobes from the write control to the storage datapath.
  typedef struct packed {
    logic clrAll;    // zero every register at this edge
    logic singleGo;  // commit the single-register write
    logic pairGo;    // commit the pair write
  } nrfStrobe_t;

endpackage

// File: rtl/nrf_ctrl.sv
`timescale 1ns/1ps
// Write control: resolves clear priority and single/pair collisions
// into a compact set of strobes for the datapath.
module nrf_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic                 clr,
  input  logic                 singleWe,
  input  logic                 pairWe,
  input  logic [IDX_W-1:0]     singleWrIdx,
  input  logic [IDX_W-2:0]     pairWrIdx,
  output nrf_pkg::nrfStrobe_t  strobe
);

  // The single target lies inside the pair being written when the
  // index with its lowest bit dropped equals the pair index.
  logic samePair;
  assign samePair = (singleWrIdx[IDX_W-1:1] == pairWrIdx);

  always_comb begin
    strobe.clrAll   = clr;
    strobe.pairGo   = pairWe && !clr;
    strobe.singleGo = singleWe && !clr && !(pairWe && samePair);
  end

endmodule

// File: rtl/nrf_datapath.sv
`timescale 1ns/1ps
// Storage and read muxes for the nibble register file.
module nrf_datapath #(
  parameter int NUM_REGS = 16,
  parameter int NIB_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int PAIR_W  = IDX_W - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nrf_pkg::nrfStrobe_t  strobe,
  input  logic [IDX_W-1:0]     singleWrIdx,
  input  logic [NIB_W-1:0]     singleWrData,
  input  logic [PAIR_W-1:0]    pairWrIdx,
  input  logic [2*NIB_W-1:0]   pairWrData,
  input  logic [IDX_W-1:0]     singleRdIdx,
  input  logic [PAIR_W-1:0]    pairRdIdx,
  output logic [NIB_W-1:0]     singleRdData,
  output logic [2*NIB_W-1:0]   pairRdData
);

  localparam int FLAT_W = NUM_REGS * NIB_W;

  logic [NUM_REGS-1:0][NIB_W-1:0] regFile;
  logic [FLAT_W-1:0]              regFlat;

  logic [NIB_W-1:0] pairHi;
  logic [NIB_W-1:0] pairLo;
  assign pairHi = pairWrData[2*NIB_W-1:NIB_W];
  assign pairLo = pairWrData[NIB_W-1:0];

  // The pair write is issued last, so on a shared target it is the one kept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (strobe.clrAll) begin
      regFile <= '0;
    end else begin
      if (strobe.singleGo) regFile[singleWrIdx] <= singleWrData;
      if (strobe.pairGo) begin
        regFile[{pairWrIdx, 1'b0}] <= pairHi;
        regFile[{pairWrIdx, 1'b1}] <= pairLo;
      end
    end
  end

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_flat
      assign regFlat[gi*NIB_W +: NIB_W] = regFile[gi];
    end
  endgenerate

  assign singleRdData = regFile[singleRdIdx];
  assign pairRdData   = {regFile[{pairRdIdx, 1'b0}], regFile[{pairRdIdx, 1'b1}]};

  // R1 and R10: a clear edge leaves nothing but zeros, even with writes pending.
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (regFlat == '0));

  p_single_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.singleGo |=> (regFile[$past(singleWrIdx)] == $past(singleWrData)));

  p_pair_even_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pairGo |=> (regFile[{$past(pairWrIdx), 1'b0}] == $past(pairHi)));

  p_pair_odd_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pairGo |=> (regFile[{$past(pairWrIdx), 1'b1}] == $past(pairLo)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clrAll || strobe.singleGo || strobe.pairGo) |=> $stable(regFlat));

endmodule

// File: rtl/nibble_regfile.sv
`timescale 1ns/1ps
// Thin top: sixteen nibble registers with single and pair views.
module nibble_regfile #(
  parameter int NUM_REGS = 16,
  parameter int NIB_W    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int PAIR_W  = IDX_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               singleWe,
  input  logic [IDX_W-1:0]   singleWrIdx,
  input  logic [NIB_W-1:0]   singleWrData,
  input  logic               pairWe,
  input  logic [PAIR_W-1:0]  pairWrIdx,
  input  logic [2*NIB_W-1:0] pairWrData,
  input  logic [IDX_W-1:0]   singleRdIdx,
  output logic [NIB_W-1:0]   singleRdData,
  input  logic [PAIR_W-1:0]  pairRdIdx,
  output logic [2*NIB_W-1:0] pairRdData
);

  nrf_pkg::nrfStrobe_t strobe;

  nrf_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clr         (clr),
    .singleWe    (singleWe),
    .pairWe      (pairWe),
    .singleWrIdx (singleWrIdx),
    .pairWrIdx   (pairWrIdx),
    .strobe      (strobe)
  );

  nrf_datapath #(.NUM_REGS(NUM_REGS), .NIB_W(NIB_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .singleWrIdx  (singleWrIdx),
    .singleWrData (singleWrData),
    .pairWrIdx    (pairWrIdx),
    .pairWrData   (pairWrData),
    .singleRdIdx  (singleRdIdx),
    .pairRdIdx    (pairRdIdx),
    .singleRdData (singleRdData),
    .pairRdData   (pairRdData)
  );

endmodule

// File: tb/test_nibble_regfile.sv
`timescale 1ns/1ps
module test_nibble_regfile;

  localparam int NREG = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clr = 1'b0;
  logic       singleWe = 1'b0;
  logic [3:0] singleWrIdx = '0;
  logic [3:0] singleWrData = '0;
  logic       pairWe = 1'b0;
  logic [2:0] pairWrIdx = '0;
  logic [7:0] pairWrData = '0;
  logic [3:0] singleRdIdx = '0;
  logic [2:0] pairRdIdx = '0;
  wire  [3:0] singleRdData;
  wire  [7:0] pairRdData;

  always #2.5 clk = ~clk;

  nibble_regfile i_nibble_regfile (
    .clk(clk), .rstN(rstN), .clr(clr),
    .singleWe(singleWe), .singleWrIdx(singleWrIdx), .singleWrData(singleWrData),
    .pairWe(pairWe), .pairWrIdx(pairWrIdx), .pairWrData(pairWrData),
    .singleRdIdx(singleRdIdx), .singleRdData(singleRdData),
    .pairRdIdx(pairRdIdx), .pairRdData(pairRdData)
  );

  int nCmp = 0;
  int nBad = 0;
  logic [3:0] mdl [NREG];

  typedef struct {
    logic [3:0] sIdx;
    logic [2:0] pIdx;
    logic [3:0] sExp;
    logic [7:0] pExp;
    string      tag;
  } item_t;

  item_t q[$];

  // One write cycle; the model follows the requirements at the edge.
  task automatic wrCycle(input bit c, input bit sw, input logic [3:0] si,
                         input logic [3:0] sd, input bit pw,
                         input logic [2:0] pi, input logic [7:0] pd);
    @(negedge clk);
    clr = c; singleWe = sw; singleWrIdx = si; singleWrData = sd;
    pairWe = pw; pairWrIdx = pi; pairWrData = pd;
    @(posedge clk);
    if (c) begin
      for (int k = 0; k < NREG; k++) mdl[k] = '0;
    end else begin
      if (sw) mdl[si] = sd;
      if (pw) begin
        mdl[2*pi]   = pd[7:4];
        mdl[2*pi+1] = pd[3:0];
      end
    end
  endtask

  // Drive read indices with writes idle and queue the expected results.
  task automatic readCheck(input logic [3:0] si, input logic [2:0] pi, input string tag);
    item_t it;
    @(negedge clk);
    clr = 1'b0; singleWe = 1'b0; pairWe = 1'b0;
    singleRdIdx = si; pairRdIdx = pi;
    it.sIdx = si; it.pIdx = pi; it.sExp = mdl[si];
    it.pExp = {mdl[2*pi], mdl[2*pi+1]}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic readAll(input string tag);
    for (int k = 0; k < NREG; k++) readCheck(4'(k), 3'(k/2), tag);
  endtask

  // Monitor: 1 ns after the driving edge, before any write edge (R11).
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        it = q.pop_front();
        nCmp++;
        if (singleRdData !== it.sExp) begin
          nBad++;
          $display("FAIL %s single[%0d]: actual %h expected %h", it.tag, it.sIdx, singleRdData, it.sExp);
        end
        nCmp++;
        if (pairRdData !== it.pExp) begin
          nBad++;
          $display("FAIL %s pair[%0d]: actual %h expected %h", it.tag, it.pIdx, pairRdData, it.pExp);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    readAll("R1_reset");

    // Single writes, read back through both views.
    for (int k = 0; k < NREG; k++) wrCycle(0, 1, 4'(k), 4'(k) ^ 4'h9, 0, 3'd0, 8'h00);
    readAll("R2_R5_R6");
    wrCycle(0, 1, 4'd7, 4'h1, 0, 3'd0, 8'h00);
    readCheck(4'd7, 3'd3, "R6_odd");
    wrCycle(0, 1, 4'd6, 4'hE, 0, 3'd0, 8'h00);
    readCheck(4'd6, 3'd3, "R6_even");

    // Pair writes, read back through both views.
    for (int k = 0; k < 8; k++) wrCycle(0, 0, 4'd0, 4'd0, 1, 3'(k), {4'(k + 3), ~4'(k)});
    readAll("R3_R4_R7");
    readCheck(4'd15, 3'd0, "R11_mixed");
    readCheck(4'd2, 3'd7, "R11_mixed");

    // Collisions: pair wins on a shared register, else both land.
    wrCycle(0, 1, 4'd5, 4'hF, 1, 3'd2, 8'h3C);
    readCheck(4'd5, 3'd2, "R8_odd");
    readCheck(4'd4, 3'd2, "R8_odd");
    wrCycle(0, 1, 4'd8, 4'h7, 1, 3'd4, 8'hE2);
    readCheck(4'd8, 3'd4, "R8_even");
    wrCycle(0, 1, 4'd0, 4'hB, 1, 3'd6, 8'h5D);
    readCheck(4'd0, 3'd6, "R8_disjoint");
    readCheck(4'd13, 3'd0, "R8_disjoint");

    // Idle cycles with busy write buses.
    wrCycle(0, 0, 4'd3, 4'hF, 0, 3'd1, 8'hFF);
    wrCycle(0, 0, 4'd9, 4'h0, 0, 3'd5, 8'h00);
    readAll("R9_hold");

    // Clear together with both writes.
    wrCycle(1, 1, 4'd2, 4'hA, 1, 3'd5, 8'h99);
    readAll("R10_R1_clear");

    // Refill, then asynchronous reset.
    wrCycle(0, 0, 4'd0, 4'd0, 1, 3'd3, 8'hA5);
    readCheck(4'd7, 3'd3, "R7_refill");
    @(negedge clk) rstN = 1'b0;
    for (int k = 0; k < NREG; k++) mdl[k] = '0;
    @(negedge clk) rstN = 1'b1;
    readAll("R1_async");

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule